// File: doc/BRIEF.md
# Dual-Clock Reset-Addressed Line Delay Memory

This block is a line buffer of 1152 words by 8 bits whose write side and read side run on two unrelated clocks. Each side has its own active-low enable, its own active-low reset and its own address counter. The block does not act as a flag-driven queue. Instead, each counter is brought back to word zero only by its own reset pulse. The distance between the write and read positions, which is the delay of the line, is therefore set entirely by when the two resets are pulsed.

A captured write word reaches the storage array one write-clock edge after it is taken in. A read placed too close behind a write therefore still sees the previous contents of that location. Read data is registered on the read clock. An output-valid indication, `q_drive`, takes the place of a tri-state output driver: it is high only after a cycle in which a read actually took place.

Top module: `line_delay_mem`

## Requirements
- R1: Both address counters step through words 0 to 1151 and wrap from 1151 back to 0. A read stream longer than 1152 words starts again at word 0.
- R2: When `w_en_n` is low at a rising `w_clk` edge and `w_rst_n` is high, the byte on `w_data` is captured for the word at the write counter, and the counter advances by one.
- R3: A captured word is written into the array at the next rising `w_clk` edge. On a shared clock, a read reset two edges after the write reset returns each newly written word. A read reset on the same edge as the write reset returns the previous contents of each word.
- R4: When `r_en_n` is low at a rising `r_clk` edge and `r_rst_n` is high, `q_data` shows the word at the read counter after that edge, `q_drive` is 1, and the read counter advances.
- R5: When `r_en_n` is high at a rising `r_clk` edge, `q_drive` is 0 after that edge. The read counter holds, so the next enabled read returns the next word in sequence.
- R6: When `w_rst_n` is low at a rising `w_clk` edge, the write counter becomes 0. Nothing is captured in that cycle, even if `w_en_n` is low.
- R7: When `r_rst_n` is low at a rising `r_clk` edge, the read counter becomes 0 and `q_drive` is 0 after that edge, even if `r_en_n` is low. After reset, `q_drive` is 0.
- R8: With both resets pulsed on the same edge of a common clock and both enables held low, read number j (counted from 0 after the reset) returns the word from write number j-1152. This is a delay of one full line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| w_clk | input | 1 | Write-side clock |
| w_en_n | input | 1 | Write enable, active low |
| w_rst_n | input | 1 | Write counter reset, synchronous, active low |
| w_data | input | 8 | Byte to be written |
| r_clk | input | 1 | Read-side clock |
| r_en_n | input | 1 | Read enable, active low |
| r_rst_n | input | 1 | Read counter reset, synchronous, active low |
| q_data | output | 8 | Registered read byte |
| q_drive | output | 1 | High when q_data holds a word read in the last cycle |

## Verification
The hardest situation to reach is the exact edge-by-edge relation between the two resets that decides whether a read sees the new word or the old word of a location. With free-running, unrelated clocks this spacing cannot be placed reliably. The bench therefore switches the read clock to follow the write clock for the delay tests. It pulses both resets on one edge to obtain the full-line delay, and checks that the first 1152 reads return the previous line. It then places the read reset two edges after the write reset to reach the shortest legal spacing. The table-driven part runs the clocks at unrelated periods and inserts idle cycles on either side to exercise address holding and wrap.

// File: rtl/lm_pkg.sv
// Shared sizing constants for the line delay memory.
// Assumes: a single word width and depth for the whole block.
package lm_pkg;
    parameter int LM_DEPTH = 1152;
    parameter int LM_WIDTH = 8;
endpackage

// File: rtl/lm_addr_ctr.sv
// Wrapping word address counter for one port of the line memory.
// Reset (active low, synchronous) forces word zero and beats the enable;
// an active-low enable advances by one and wraps after DEPTH-1.
// Assumes: DEPTH >= 2.
module lm_addr_ctr #(
    parameter int DEPTH = 1152,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Counter update: reset to zero, else step with wrap when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (!en_n)
            addr <= (addr == LAST) ? '0 : addr + 1'b1;
    end

    // R6 / R7: a reset edge leaves the counter at word zero.
    a_r6_ctr_rst_zero: assert property (@(posedge clk)
        !rst_n |=> addr == '0);

    // R5: an idle cycle keeps the address.
    a_r5_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> $stable(addr));

    // R1: an enabled step from the last word lands on zero.
    a_r1_ctr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && addr == LAST) |=> addr == '0);

    // R1: the counter never leaves the legal range.
    a_r1_ctr_range: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST);
endmodule

// File: rtl/lm_wr_stage.sv
// Write capture stage: holds a captured word and its address for one
// write-clock cycle, then presents it to the array as a commit request.
// Assumes: address comes from the write counter in the same clock domain.
module lm_wr_stage #(
    parameter int DEPTH = 1152,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic [AW-1:0]    cap_addr,
    input  logic [WIDTH-1:0] cap_data,
    output logic             cm_valid,
    output logic [AW-1:0]    cm_addr,
    output logic [WIDTH-1:0] cm_data
);
    // Capture register: reset suppresses capture, enable low takes a word.
    always_ff @(posedge clk) begin
        cm_valid <= rst_n && !en_n;
        if (rst_n && !en_n) begin
            cm_addr <= cap_addr;
            cm_data <= cap_data;
        end
    end

    // R3: a capture edge yields a commit request on the following edge.
    a_r3_commit_next: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n |=> cm_valid && cm_addr == $past(cap_addr));

    // R6: a reset edge never produces a commit.
    a_r6_no_commit_in_rst: assert property (@(posedge clk)
        !rst_n |=> !cm_valid);
endmodule

// File: rtl/lm_store.sv
// Storage array: written on the write clock from the commit stage,
// read combinationally at the read address for the read-side register.
// Assumes: read and write addresses stay below DEPTH.
module lm_store #(
    parameter int DEPTH = 1152,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             w_clk,
    input  logic             wr_valid,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] cells [DEPTH];

    // Array write: one committed word per write-clock edge.
    always_ff @(posedge w_clk) begin
        if (wr_valid)
            cells[wr_addr] <= wr_data;
    end

    // Array read: current word at the read address.
    assign rd_word = cells[rd_addr];
endmodule

// File: rtl/lm_rd_port.sv
// Read output register: latches the addressed word when a read is
// enabled and flags it as driven; idle or reset cycles drop the flag.
// Assumes: rd_word is the array word at the read counter's address.
module lm_rd_port #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic [WIDTH-1:0] rd_word,
    output logic [WIDTH-1:0] q,
    output logic             q_on
);
    // Output register: load on an enabled read, otherwise hold the data.
    always_ff @(posedge clk) begin
        q_on <= rst_n && !en_n;
        if (rst_n && !en_n)
            q <= rd_word;
    end

    // R5: an idle read cycle leaves the output undriven.
    a_r5_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> !q_on);

    // R7: a reset edge leaves the output undriven.
    a_r7_rst_off: assert property (@(posedge clk)
        !rst_n |=> !q_on);

    // R4: an enabled read drives the output with the addressed word.
    a_r4_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n |=> q_on && q == $past(rd_word));
endmodule

// File: rtl/line_delay_mem.sv
// Dual-clock line delay memory. Write and read sides each own a counter
// reset by their own pulse; the delay is set by when those pulses occur.
// Assumes: all inputs of a side are synchronous to that side's clock.
module line_delay_mem #(
    parameter int DEPTH = lm_pkg::LM_DEPTH,
    parameter int WIDTH = lm_pkg::LM_WIDTH
) (
    input  logic             w_clk,
    input  logic             w_en_n,
    input  logic             w_rst_n,
    input  logic [WIDTH-1:0] w_data,
    input  logic             r_clk,
    input  logic             r_en_n,
    input  logic             r_rst_n,
    output logic [WIDTH-1:0] q_data,
    output logic             q_drive
);
    localparam int AW    = $clog2(DEPTH);
    localparam int PORTS = 2;

    logic [PORTS-1:0]  pclk;
    logic [PORTS-1:0]  prst_n;
    logic [PORTS-1:0]  pen_n;
    logic [AW-1:0]     paddr [PORTS];

    logic              cm_valid;
    logic [AW-1:0]     cm_addr;
    logic [WIDTH-1:0]  cm_data;
    logic [WIDTH-1:0]  rd_word;

    // Port 0 is the write side, port 1 the read side.
    assign pclk   = {r_clk,   w_clk};
    assign prst_n = {r_rst_n, w_rst_n};
    assign pen_n  = {r_en_n,  w_en_n};

    // One address counter per port.
    for (genvar p = 0; p < PORTS; p++) begin : g_ctr
        lm_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
            .clk   (pclk[p]),
            .rst_n (prst_n[p]),
            .en_n  (pen_n[p]),
            .addr  (paddr[p])
        );
    end

    lm_wr_stage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_wr (
        .clk      (w_clk),
        .rst_n    (w_rst_n),
        .en_n     (w_en_n),
        .cap_addr (paddr[0]),
        .cap_data (w_data),
        .cm_valid (cm_valid),
        .cm_addr  (cm_addr),
        .cm_data  (cm_data)
    );

    lm_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .w_clk    (w_clk),
        .wr_valid (cm_valid),
        .wr_addr  (cm_addr),
        .wr_data  (cm_data),
        .rd_addr  (paddr[1]),
        .rd_word  (rd_word)
    );

    lm_rd_port #(.WIDTH(WIDTH)) u_rd (
        .clk     (r_clk),
        .rst_n   (r_rst_n),
        .en_n    (r_en_n),
        .rd_word (rd_word),
        .q       (q_data),
        .q_on    (q_drive)
    );

    // R2: each enabled write edge advances the write address by one step.
    a_r2_write_step: assert property (@(posedge w_clk) disable iff (!w_rst_n)
        (!w_en_n && paddr[0] != AW'(DEPTH - 1)) |=> paddr[0] == $past(paddr[0]) + 1'b1);

    // R3: the commit address is the one the write counter held a cycle ago.
    a_r3_commit_addr: assert property (@(posedge w_clk) disable iff (!w_rst_n)
        cm_valid |-> $past(paddr[0]) == cm_addr);

    // R4: an enabled read edge advances the read address.
    a_r4_read_step: assert property (@(posedge r_clk) disable iff (!r_rst_n)
        (!r_en_n && paddr[1] != AW'(DEPTH - 1)) |=> paddr[1] == $past(paddr[1]) + 1'b1);
endmodule

// File: tb/line_delay_mem_test.sv
module line_delay_mem_test;
    localparam int N = 1152;

    logic       w_clk = 1'b0;
    logic       r_free = 1'b0;
    logic       same_clk = 1'b0;
    logic       r_clk;
    logic       w_en_n, w_rst_n, r_en_n, r_rst_n;
    logic [7:0] w_data;
    logic [7:0] q_data;
    logic       q_drive;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    always #5 w_clk = ~w_clk;
    always #7 r_free = ~r_free;
    assign r_clk = same_clk ? w_clk : r_free;

    line_delay_mem uut (
        .w_clk(w_clk), .w_en_n(w_en_n), .w_rst_n(w_rst_n), .w_data(w_data),
        .r_clk(r_clk), .r_en_n(r_en_n), .r_rst_n(r_rst_n),
        .q_data(q_data), .q_drive(q_drive)
    );

    // Vector fields: seed[39:32], write gap[31:24], read gap[23:16], read length[15:0].
    localparam logic [39:0] VEC [4] = '{
        {8'h11, 8'd0, 8'd0, 16'd1152},
        {8'h5A, 8'd3, 8'd0, 16'd600},
        {8'hC3, 8'd0, 8'd2, 16'd1160},
        {8'h27, 8'd5, 8'd4, 16'd300}
    };

    function automatic logic [7:0] pat(input logic [7:0] s, input int i);
        return (s + 8'(i * 7)) ^ 8'(i >> 8);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_line(input logic [7:0] seed, input int gap);
        int i = 0;
        int c = 0;
        @(negedge w_clk); w_rst_n = 1'b0; w_en_n = 1'b1;
        @(negedge w_clk); w_rst_n = 1'b1;
        while (i < N) begin
            if (gap != 0 && (c % gap) == gap - 1) begin
                w_en_n = 1'b1;
            end else begin
                w_en_n = 1'b0;
                w_data = pat(seed, i);
                i++;
            end
            c++;
            @(negedge w_clk);
        end
        w_en_n = 1'b1;
        repeat (2) @(negedge w_clk);
    endtask

    task automatic rd_stream(input logic [7:0] seed, input int gap, input int len);
        int j = 0;
        int c = 0;
        bit idle;
        @(negedge r_clk); r_rst_n = 1'b0; r_en_n = 1'b1;
        @(negedge r_clk); r_rst_n = 1'b1;
        while (j < len) begin
            idle = (gap != 0 && (c % gap) == gap - 1);
            r_en_n = idle;
            @(posedge r_clk); #1;
            if (idle) begin
                chk("R5 idle drive", {7'd0, q_drive}, 8'd0);
            end else begin
                chk("R4 drive", {7'd0, q_drive}, 8'd1);
                chk(j >= N ? "R1 wrap data" : "R4 data", q_data, pat(seed, j % N));
                j++;
            end
            c++;
            @(negedge r_clk);
        end
        r_en_n = 1'b1;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #1500000;
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        w_en_n = 1'b1; r_en_n = 1'b1; w_rst_n = 1'b0; r_rst_n = 1'b0; w_data = 8'h00;
        repeat (3) @(posedge w_clk);
        repeat (3) @(posedge r_clk);
        #1;
        // R7: reset state.
        chk("R7 reset drive", {7'd0, q_drive}, 8'd0);
        w_rst_n = 1'b1; r_rst_n = 1'b1;

        // Table walk: R2, R4, R5, R1 under unrelated clocks.
        foreach (VEC[v]) begin
            wr_line(VEC[v][39:32], int'(VEC[v][31:24]));
            rd_stream(VEC[v][39:32], int'(VEC[v][23:16]), int'(VEC[v][15:0]));
        end

        // R6: write reset with enable low captures nothing.
        @(negedge w_clk); w_rst_n = 1'b0; w_en_n = 1'b0; w_data = 8'hFF;
        @(negedge w_clk); w_rst_n = 1'b1; w_en_n = 1'b1;
        repeat (3) @(negedge w_clk);
        // R7: read reset with enable low gives no output, then restarts at word 0.
        @(negedge r_clk); r_rst_n = 1'b0; r_en_n = 1'b0;
        @(posedge r_clk); #1;
        chk("R7 reset beats enable", {7'd0, q_drive}, 8'd0);
        @(negedge r_clk); r_rst_n = 1'b1;
        @(posedge r_clk); #1;
        chk("R6 word0 untouched", q_data, pat(8'h27, 0));
        @(negedge r_clk);
        @(posedge r_clk); #1;
        chk("R7 restart sequence", q_data, pat(8'h27, 1));
        @(negedge r_clk); r_en_n = 1'b1;

        // Shared clock for the reset-spacing tests.
        @(negedge w_clk); same_clk = 1'b1;
        repeat (3) @(negedge w_clk);

        // R8: both resets on one edge -> full-line delay; first line is old data (R3).
        w_rst_n = 1'b0; r_rst_n = 1'b0;
        @(negedge w_clk);
        w_rst_n = 1'b1; r_rst_n = 1'b1; w_en_n = 1'b0; r_en_n = 1'b0;
        w_data = pat(8'h99, 0);
        for (int k = 0; k < 2 * N; k++) begin
            @(posedge w_clk); #1;
            if (k < N) chk("R3 old line", q_data, pat(8'h27, k));
            else       chk("R8 line delay", q_data, pat(8'h99, k - N));
            @(negedge w_clk);
            w_data = pat(8'h99, k + 1);
        end
        w_en_n = 1'b1; r_en_n = 1'b1;

        // R3: read reset two edges after write reset -> fresh words.
        @(negedge w_clk); w_rst_n = 1'b0;
        @(negedge w_clk); w_rst_n = 1'b1; w_en_n = 1'b0; w_data = pat(8'h4E, 0);
        for (int e = 1; e <= 40; e++) begin
            r_rst_n = (e == 2) ? 1'b0 : 1'b1;
            r_en_n  = (e >= 3) ? 1'b0 : 1'b1;
            @(posedge w_clk); #1;
            if (e >= 3) chk("R3 shortest spacing", q_data, pat(8'h4E, e - 3));
            @(negedge w_clk);
            w_data = pat(8'h4E, e);
        end
        w_en_n = 1'b1; r_en_n = 1'b1; r_rst_n = 1'b1;
        repeat (2) @(negedge w_clk);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule